// File: doc/BRIEF.md
# Dual-Section Decade / Bi-Quinary Counter

This block is a four-bit counter made of two sections that can run apart or be joined: a toggle stage that divides by two (output `qa`) and a three-bit stage that divides by five (outputs `qd`, `qc`, `qb`, with `qd` as its top bit). Each section has its own count input. A section advances when its input goes from high to low. The whole block runs on one system clock. Both count inputs pass through a synchronizer and a falling-edge detector, so they may be slow and asynchronous to that clock.

A static strap (`chain_sel`) picks how the sections are joined. With the independent setting, each section follows its own input. With the decade setting, the two-stage feeds the five-stage, and `{qd,qc,qb,qa}` counts 0 to 9 in binary. With the bi-quinary setting, the five-stage takes the input and its top bit feeds the two-stage. `qa` then becomes a square wave at one tenth of the input rate, with equal high and low times.

One active-high clear (`clr`) acts on both sections. It drives all outputs low at once, without waiting for a clock, and its release is synchronized to the system clock. In a chain the downstream section changes one clock after the upstream one. A decoded combination of the outputs can therefore show a short false value and is not glitch-free.

Top module: `bqc_counter`

## Requirements
- R1: Each section moves only on a high-to-low transition of the input that drives it. A rising edge, or a held level, leaves all outputs unchanged, and a pulse on one section's input never changes the other section in the independent setting.
- R2: While `clr` is high, `qa`, `qb`, `qc` and `qd` are all 0, with no clock edge needed, and input pulses are not counted.
- R3: In the independent setting (`chain_sel` = 2'b00), `qa` toggles once for every falling edge of `cnt_a`.
- R4: The five-stage, read as `{qd,qc,qb}`, steps 000, 001, 010, 011, 100 and then returns to 000. It never holds a value above 100.
- R5: In the decade setting (`chain_sel` = 2'b01), a falling `qa` advances the five-stage. After n falling edges of `cnt_a`, `{qd,qc,qb,qa}` equals n mod 10 in binary, and `cnt_b` is ignored.
- R6: In the bi-quinary setting (`chain_sel` = 2'b10), `cnt_b` drives the five-stage and a falling `qd` toggles `qa`. After n falling edges of `cnt_b`, `{qa,qd,qc,qb}` equals {(n/5) mod 2, n mod 5}, so `qa` changes every fifth count. `cnt_a` is ignored.
- R7: With default parameters, a section driven by an input changes on the third rising clock edge after that input falls. A chained downstream section changes one edge after that.
- R8: `chain_sel` is captured only while the block is in reset. Changing it after `clr` is released has no effect until the next clear.
- R9: An input held high across the release of `clr` is not counted. Its next falling edge is counted normally.
- R10: `chain_sel` = 2'b11 behaves the same as the independent setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Active-high clear. Asserts without a clock, releases in step with the clock |
| chain_sel | input | 2 | Chaining strap: 00 independent, 01 decade, 10 bi-quinary, 11 independent |
| cnt_a | input | 1 | Count input of the divide-by-two section |
| cnt_b | input | 1 | Count input of the divide-by-five section |
| qa | output | 1 | Divide-by-two output |
| qb | output | 1 | Divide-by-five output, least significant bit |
| qc | output | 1 | Divide-by-five output, middle bit |
| qd | output | 1 | Divide-by-five output, most significant bit |

## Verification
The bench builds the block with its defaults: two synchronizer flops on each count input and two flops on the reset release. Under these defaults the three-edge latency of an input-driven section, and the extra edge of a chained section, can be checked on exact clock edges. That includes the edge in the decade setting where `qa` has already fallen but the five-stage has not yet moved. Runs of 25 pulses in the decade and bi-quinary settings take both chains through two full wraps. A clear in the middle of a count and an input held high across reset release exercise the reset corner cases.

// File: rtl/bqc_pkg.sv
package bqc_pkg;
  // Chaining strap encodings
  typedef enum logic [1:0] {
    CH_INDEP = 2'b00,
    CH_DEC   = 2'b01,
    CH_BIQ   = 2'b10,
    CH_SPARE = 2'b11
  } chain_e;

  localparam int LO_MOD = 2;
  localparam int HI_MOD = 5;
  localparam int LO_W   = $clog2(LO_MOD);
  localparam int HI_W   = $clog2(HI_MOD);
endpackage

// File: rtl/bqc_rst_sync.sv
module bqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  output logic rst_o
);
  logic [STAGES-1:0] rs_q;
  logic [STAGES-1:0] rs_d;

  always_comb begin
    rs_d = {rs_q[STAGES-2:0], 1'b0};
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) rs_q <= '1;
    else     rs_q <= rs_d;
  end

  assign rst_o = rs_q[STAGES-1];
endmodule

// File: rtl/bqc_fall_det.sv
module bqc_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  localparam int TOP = SYNC_STAGES;

  logic [TOP:0] sh_q;
  logic [TOP:0] sh_d;

  always_comb begin
    sh_d = {sh_q[TOP-1:0], din};
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sh_q <= '0;
    else     sh_q <= sh_d;
  end

  // oldest synchronized sample high, newer one low
  assign fall = sh_q[TOP] & ~sh_q[TOP-1];
endmodule

// File: rtl/bqc_mod_stage.sv
module bqc_mod_stage #(
  parameter int MOD = 5,
  parameter int W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (cnt_q == W'(MOD - 1)) cnt_d = '0;
    else                      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/bqc_counter.sv
module bqc_counter
  import bqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       clr,
  input  logic [1:0] chain_sel,
  input  logic       cnt_a,
  input  logic       cnt_b,
  output logic       qa,
  output logic       qb,
  output logic       qc,
  output logic       qd
);
  logic            rst_i;
  chain_e          mode_q;
  logic            a_fall, b_fall;
  logic            qa_prev_q, qd_prev_q;
  logic            qa_fall, qd_fall;
  logic            en2, en5;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;

  bqc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk  (clk),
    .clr  (clr),
    .rst_o(rst_i)
  );

  // strap capture, open only during reset
  always_ff @(posedge clk) begin
    if (rst_i) mode_q <= chain_e'(chain_sel);
  end

  bqc_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fall_a (
    .clk (clk),
    .rst (rst_i),
    .din (cnt_a),
    .fall(a_fall)
  );

  bqc_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fall_b (
    .clk (clk),
    .rst (rst_i),
    .din (cnt_b),
    .fall(b_fall)
  );

  // registered copies of the section outputs for chaining
  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) begin
      qa_prev_q <= 1'b0;
      qd_prev_q <= 1'b0;
    end else begin
      qa_prev_q <= lo_cnt[0];
      qd_prev_q <= hi_cnt[HI_W-1];
    end
  end

  assign qa_fall = qa_prev_q & ~lo_cnt[0];
  assign qd_fall = qd_prev_q & ~hi_cnt[HI_W-1];

  always_comb begin
    unique case (mode_q)
      CH_DEC: begin
        en2 = a_fall;
        en5 = qa_fall;
      end
      CH_BIQ: begin
        en2 = qd_fall;
        en5 = b_fall;
      end
      default: begin
        en2 = a_fall;
        en5 = b_fall;
      end
    endcase
  end

  bqc_mod_stage #(.MOD(LO_MOD), .W(LO_W)) u_lo (
    .clk(clk),
    .rst(rst_i),
    .en (en2),
    .cnt(lo_cnt)
  );

  bqc_mod_stage #(.MOD(HI_MOD), .W(HI_W)) u_hi (
    .clk(clk),
    .rst(rst_i),
    .en (en5),
    .cnt(hi_cnt)
  );

  assign qa = lo_cnt[0];
  assign qb = hi_cnt[0];
  assign qc = hi_cnt[1];
  assign qd = hi_cnt[2];
endmodule

// File: rtl/bqc_chk.sv
module bqc_chk (
  input logic       clk,
  input logic       clr,
  input logic       rst_i,
  input logic [1:0] mode_q,
  input logic       en2,
  input logic       en5,
  input logic       qa,
  input logic       qb,
  input logic       qc,
  input logic       qd
);
  logic [2:0] q5;
  assign q5 = {qd, qc, qb};

  AST_CLR_ZERO: assert property (@(posedge clk)
    clr |-> ({qa, qb, qc, qd} == 4'b0000)); // R2

  AST_QA_NEEDS_EN: assert property (@(posedge clk) disable iff (rst_i)
    !$stable(qa) |-> $past(en2)); // R3

  AST_Q5_STEP: assert property (@(posedge clk) disable iff (rst_i)
    !$stable(q5) |-> ($past(en5) &&
      (($past(q5) == 3'd4) ? (q5 == 3'd0) : (q5 == $past(q5) + 3'd1)))); // R4

  AST_Q5_RANGE: assert property (@(posedge clk) disable iff (rst_i)
    q5 <= 3'd4); // R4

  AST_DEC_RANGE: assert property (@(posedge clk) disable iff (rst_i)
    (mode_q == 2'b01) |-> ({qd, qc, qb, qa} <= 4'd9)); // R5

  AST_BIQ_QA_AT_WRAP: assert property (@(posedge clk) disable iff (rst_i)
    ((mode_q == 2'b10) && !$stable(qa)) |-> (q5 == 3'd0)); // R6
endmodule

bind bqc_counter bqc_chk u_chk (
  .clk   (clk),
  .clr   (clr),
  .rst_i (rst_i),
  .mode_q(mode_q),
  .en2   (en2),
  .en5   (en5),
  .qa    (qa),
  .qb    (qb),
  .qc    (qc),
  .qd    (qd)
);

// File: tb/sim_bqc_counter.sv
module sim_bqc_counter;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic [1:0] chain_sel = 2'b00;
  logic       cnt_a = 1'b0;
  logic       cnt_b = 1'b0;
  logic       qa, qb, qc, qd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bqc_counter u0 (
    .clk(clk), .clr(clr), .chain_sel(chain_sel),
    .cnt_a(cnt_a), .cnt_b(cnt_b),
    .qa(qa), .qb(qb), .qc(qc), .qd(qd)
  );

  function automatic logic [3:0] bin_view();
    return {qd, qc, qb, qa};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic apply_reset(input logic [1:0] sel);
    @(negedge clk);
    clr = 1'b1;
    chain_sel = sel;
    repeat (4) @(negedge clk);
    clr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_a();
    @(negedge clk); cnt_a = 1'b1;
    repeat (4) @(negedge clk); cnt_a = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_b();
    @(negedge clk); cnt_b = 1'b1;
    repeat (4) @(negedge clk); cnt_b = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset_state();
    repeat (2) @(negedge clk);
    chk("R2", "outputs during clear", bin_view(), 4'b0000);
  endtask

  task automatic t_independent();
    int na = 0;
    int nb = 0;
    apply_reset(2'b00);
    chk("R2", "after release", bin_view(), 4'b0000);
    // rising edge and held high: no change
    @(negedge clk); cnt_a = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1", "rising/held cnt_a", bin_view(), 4'b0000);
    cnt_a = 1'b0;
    repeat (6) @(negedge clk);
    na = 1;
    chk("R3", "qa after first fall", {3'b000, qa}, 4'b0001);
    for (int i = 0; i < 4; i++) begin
      pulse_a(); na++;
      chk("R3", "qa toggle", {3'b000, qa}, 4'(na % 2));
      chk("R1", "five-stage untouched by cnt_a", {1'b0, qd, qc, qb}, 4'b0000);
    end
    for (int i = 0; i < 7; i++) begin
      pulse_b(); nb++;
      chk("R4", "five-stage step", {1'b0, qd, qc, qb}, 4'(nb % 5));
      chk("R1", "qa untouched by cnt_b", {3'b000, qa}, 4'(na % 2));
    end
    // latency: five-stage now at 2
    @(negedge clk); cnt_b = 1'b1;
    repeat (4) @(negedge clk); cnt_b = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R7", "no change at second edge", {1'b0, qd, qc, qb}, 4'd2);
    @(posedge clk); #1;
    chk("R7", "change at third edge", {1'b0, qd, qc, qb}, 4'd3);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_decade();
    int n = 0;
    apply_reset(2'b01);
    pulse_a(); n = 1;
    chk("R5", "decade count 1", bin_view(), 4'd1);
    // chained latency on 1 -> 2
    @(negedge clk); cnt_a = 1'b1;
    repeat (4) @(negedge clk); cnt_a = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R7", "decade second edge", bin_view(), 4'd1);
    @(posedge clk); #1;
    chk("R7", "decade qa fallen, five-stage pending", bin_view(), 4'd0);
    @(posedge clk); #1;
    chk("R7", "decade five-stage one edge later", bin_view(), 4'd2);
    repeat (6) @(negedge clk);
    n = 2;
    for (int i = 0; i < 23; i++) begin
      pulse_a(); n++;
      chk("R5", "decade count", bin_view(), 4'(n % 10));
    end
    pulse_b(); pulse_b();
    chk("R5", "cnt_b ignored in decade", bin_view(), 4'(n % 10));
  endtask

  task automatic t_biquinary();
    int n = 0;
    int toggles = 0;
    logic last_qa;
    apply_reset(2'b10);
    last_qa = qa;
    for (int i = 0; i < 25; i++) begin
      pulse_b(); n++;
      chk("R6", "bi-quinary order",
          {qa, qd, qc, qb}, {1'((n / 5) % 2), 3'(n % 5)});
      if (qa != last_qa) toggles++;
      last_qa = qa;
    end
    chk("R6", "qa toggles in 25 counts", 4'(toggles), 4'd5);
    pulse_a(); pulse_a(); pulse_a();
    chk("R6", "cnt_a ignored in bi-quinary",
        {qa, qd, qc, qb}, {1'((n / 5) % 2), 3'(n % 5)});
  endtask

  task automatic t_spare_code();
    apply_reset(2'b11);
    pulse_a();
    chk("R10", "spare code qa", bin_view(), 4'b0001);
    pulse_b(); pulse_b();
    chk("R10", "spare code five-stage", bin_view(), 4'b0101);
  endtask

  task automatic t_mode_lock();
    apply_reset(2'b00);
    chain_sel = 2'b01;
    pulse_a(); pulse_a();
    chk("R8", "strap change after release ignored", bin_view(), 4'b0000);
    pulse_b();
    chk("R8", "independent five-stage still fed by cnt_b", bin_view(), 4'b0010);
  endtask

  task automatic t_mid_clear();
    apply_reset(2'b01);
    for (int i = 0; i < 7; i++) pulse_a();
    chk("R5", "decade at 7 before clear", bin_view(), 4'd7);
    @(negedge clk); clr = 1'b1;
    #1;
    chk("R2", "clear forces zero at once", bin_view(), 4'b0000);
    pulse_a();
    chk("R2", "no count while clear high", bin_view(), 4'b0000);
    clr = 1'b0;
    repeat (4) @(negedge clk);
    pulse_a();
    chk("R5", "counts again after clear", bin_view(), 4'd1);
  endtask

  task automatic t_held_high();
    @(negedge clk);
    clr = 1'b1; chain_sel = 2'b00; cnt_a = 1'b1;
    repeat (4) @(negedge clk);
    clr = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9", "high input across release not counted", bin_view(), 4'b0000);
    cnt_a = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9", "next fall counted", bin_view(), 4'b0001);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset_state();
    t_independent();
    t_decade();
    t_biquinary();
    t_spare_code();
    t_mode_lock();
    t_mid_clear();
    t_held_high();
    finish_up();
  end
endmodule